// File: doc/BRIEF.md
# Loop Accelerator Address and Control Unit

This unit runs a counted software loop in hardware. Software fills a small register file through a word-addressed configuration port. For each of three array walkers it sets a base address, a signed stride and an enable. It also sets the iteration bound, an early-exit condition and a result address. A start write hands the loop to the unit, and the processor can then sleep.

On every iteration, each enabled walker fetches one element from memory into its own operand register (slots 0, 1 and 2). The multiply-accumulate adds the product of slots 0 and 1, plus slot 2, to a wide accumulator. The iteration counter advances in the same cycle, with no extra cycles between iterations. The loop stops at the bound or on the selected accumulator condition. The unit then writes the low word of the accumulator to the result address and raises an interrupt. The interrupt stays up until software clears it.

Memory traffic uses one valid/ready request channel. Read data is taken from `mem_rdata` in the cycle the read request is accepted. While ready is low the unit holds its request and all of its state.

Top module: `loop_accel_ctrl`

## Requirements
- R1: After reset the status word reads 0, `irq` and `mem_req_valid` are 0, and the accumulator and every operand register read 0.
- R2: Configuration words are at these word addresses: 0 control (bit0 start, bits 2:1 exit select), 1 status (bit0 busy, bit1 done), 2 bound, 3 iterations done, 4 result address, 5 and 6 accumulator low and high words. Walker g uses words 8+4g to 11+4g for base, stride, enable (bit0) and operand register. Writable words read back what was written.
- R3: Writing control with bit0 set while idle makes the unit busy, clears done, the iteration count and the accumulator, and loads each walker's cursor from its base. While busy, every configuration write except the status done-clear is ignored.
- R4: Within an iteration, the enabled walkers issue reads in order 0, 1, 2. For iteration k (from 0), walker g reads base+k*stride. A disabled walker issues nothing and its operand register keeps its value.
- R5: When an iteration's last read is accepted, the accumulator gains signed(slot0)*signed(slot1)+signed(slot2), using the values just fetched. With ready held high, an iteration with n enabled walkers lasts exactly max(n,1) cycles.
- R6: The loop performs at most `bound` iterations. A bound of 0 performs no reads.
- R7: Exit select 1 ends the loop after the first iteration whose accumulator is zero. Select 2 ends it after the first iteration whose accumulator is negative. Selects 0 and 3 never end it early.
- R8: After the loop, exactly one write of the accumulator's low word to the result address is issued. Done is set when that write is accepted.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request address, direction and data stay stable, and no state advances.
- R10: `irq` equals the done flag. It stays set until a status write with bit1 set, or a new start. A status write with bit1 clear has no effect on it.
- R11: The iterations-done word reports the number of completed iterations of the last loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_rdata | output | DATA_W | Configuration read data (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 for the result write, 0 for reads |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_req_wdata | output | DATA_W | Result write data |
| mem_rdata | input | DATA_W | Read data, valid in the accepting cycle |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situation to reach is an early exit on one exact iteration. The accumulator is a running sum of products over three slots, so it rarely hits zero or flips sign on a chosen iteration. The stimulus first runs a one-walker loop that forces slot 0 to zero, which removes the product term. Later loops enable only walker 2, over a memory image whose value equals the address minus 0x100. A chosen base and a negative stride then make the sum reach zero, and then go negative, on known iterations. Random ready stalls, and configuration writes issued mid-loop, exercise the hold and ignore rules.

// File: rtl/lacc_pkg.sv
package lacc_pkg;
   localparam int NUM_GEN = 3;
   localparam int CFG_AW  = 5;

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WB} state_e;
   typedef enum logic [1:0] {BRK_OFF = 2'd0, BRK_ZERO = 2'd1, BRK_NEG = 2'd2, BRK_OFF2 = 2'd3} brk_e;

   localparam logic [CFG_AW-1:0] A_CTRL  = 5'd0;
   localparam logic [CFG_AW-1:0] A_STAT  = 5'd1;
   localparam logic [CFG_AW-1:0] A_BOUND = 5'd2;
   localparam logic [CFG_AW-1:0] A_ITERS = 5'd3;
   localparam logic [CFG_AW-1:0] A_WBADR = 5'd4;
   localparam logic [CFG_AW-1:0] A_ACCLO = 5'd5;
   localparam logic [CFG_AW-1:0] A_ACCHI = 5'd6;
   localparam int GEN_BASE_WORD = 8;

   localparam logic [1:0] F_BASE   = 2'd0;
   localparam logic [1:0] F_STRIDE = 2'd1;
   localparam logic [1:0] F_EN     = 2'd2;
   localparam logic [1:0] F_DATA   = 2'd3;
endpackage

// File: rtl/lacc_agu.sv
module lacc_agu #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_base,
   input  logic              wr_stride,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              load,
   input  logic              adv,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] stride_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              en_o,
   output logic [DATA_W-1:0] data_o
);
   if (ADDR_W > DATA_W) begin : g_chk_aw
      $error("lacc_agu: ADDR_W must not exceed DATA_W");
   end

   logic [ADDR_W-1:0] base_q, stride_q, addr_q;
   logic              en_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         stride_q <= '0;
         addr_q   <= '0;
         en_q     <= 1'b0;
         data_q   <= '0;
      end else begin
         if (wr_base)   base_q   <= wdata[ADDR_W-1:0];
         if (wr_stride) stride_q <= wdata[ADDR_W-1:0];
         if (wr_en)     en_q     <= wdata[0];
         if (load)      addr_q   <= base_q;
         else if (adv)  addr_q   <= addr_q + stride_q;
         if (adv)       data_q   <= rdata;
      end
   end

   assign base_o   = base_q;
   assign stride_o = stride_q;
   assign addr_o   = addr_q;
   assign en_o     = en_q;
   assign data_o   = data_q;

   // R4
   dis_adv_chk: assert property (@(posedge clk) disable iff (!rst_n) !en_q |-> !adv);
endmodule

// File: rtl/lacc_mac.sv
module lacc_mac #(
   parameter int DATA_W = 32,
   parameter int ACC_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] c,
   output logic [ACC_W-1:0]  acc_o,
   output logic [ACC_W-1:0]  acc_nxt_o
);
   localparam int PROD_W = 2 * DATA_W;

   if (ACC_W < PROD_W) begin : g_chk_acc
      $error("lacc_mac: ACC_W must hold a full product");
   end

   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  prod_x, c_x, acc_q;

   assign prod   = $signed(a) * $signed(b);
   assign prod_x = ACC_W'(prod);
   assign c_x    = ACC_W'($signed(c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (clr) acc_q <= '0;
      else if (en)  acc_q <= acc_q + prod_x + c_x;
   end

   assign acc_o     = acc_q;
   assign acc_nxt_o = acc_q + prod_x + c_x;
endmodule

// File: rtl/lacc_loopctl.sv
module lacc_loopctl #(
   parameter int CNT_W = 16,
   parameter int ACC_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             run,
   input  logic [CNT_W-1:0] bound,
   input  logic [1:0]       brk_sel,
   input  logic [ACC_W-1:0] acc_nxt,
   output logic [CNT_W-1:0] iters_o,
   output logic             finish_o
);
   import lacc_pkg::*;

   logic [CNT_W-1:0] iters_q;
   logic             brk;

   always_comb begin
      case (brk_e'(brk_sel))
         BRK_ZERO: brk = (acc_nxt == '0);
         BRK_NEG:  brk = acc_nxt[ACC_W-1];
         default:  brk = 1'b0;
      endcase
   end

   assign finish_o = step && (((iters_q + CNT_W'(1)) == bound) || brk);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    iters_q <= '0;
      else if (clr)  iters_q <= '0;
      else if (step) iters_q <= iters_q + CNT_W'(1);
   end

   assign iters_o = iters_q;

   // R6
   iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) run |-> (iters_q < bound));
endmodule

// File: rtl/loop_accel_ctrl.sv
module loop_accel_ctrl
   import lacc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int ACC_W  = 64,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [4:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              irq
);
   if (CNT_W > DATA_W) begin : g_chk_cnt
      $error("loop_accel_ctrl: CNT_W must not exceed DATA_W");
   end

   state_e           st_q;
   logic [1:0]       cur_q, brk_q;
   logic [CNT_W-1:0] bound_q, iters;
   logic [ADDR_W-1:0] wbadr_q;
   logic             done_q;

   logic [ADDR_W-1:0] g_base [NUM_GEN];
   logic [ADDR_W-1:0] g_strd [NUM_GEN];
   logic [ADDR_W-1:0] g_addr [NUM_GEN];
   logic [DATA_W-1:0] g_data [NUM_GEN];
   logic [DATA_W-1:0] g_op   [NUM_GEN];
   logic [NUM_GEN-1:0] g_en, g_adv, g_sel;
   logic [ACC_W-1:0]  acc, acc_nxt;

   logic idle, wr_ok, start, clr_done, any_en, has_nxt, rd_hs, iter_end, finish;
   logic [1:0] first_g, nxt_g;

   assign idle     = (st_q == ST_IDLE);
   assign wr_ok    = cfg_we && idle;
   assign start    = wr_ok && (cfg_addr == A_CTRL) && cfg_wdata[0];
   assign clr_done = cfg_we && (cfg_addr == A_STAT) && cfg_wdata[1];
   assign any_en   = |g_en;

   always_comb begin
      first_g = '0;
      nxt_g   = '0;
      has_nxt = 1'b0;
      for (int g = NUM_GEN - 1; g >= 0; g--) begin
         if (g_en[g]) first_g = 2'(g);
         if (g_en[g] && (g > int'(cur_q))) begin
            nxt_g   = 2'(g);
            has_nxt = 1'b1;
         end
      end
   end

   assign rd_hs    = (st_q == ST_RUN) && any_en && mem_req_ready;
   assign iter_end = (st_q == ST_RUN) && (!any_en || (mem_req_ready && !has_nxt));

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      assign g_sel[g] = wr_ok && (cfg_addr[4:2] == 3'((GEN_BASE_WORD / 4) + g));
      assign g_adv[g] = rd_hs && (cur_q == 2'(g));
      assign g_op[g]  = g_adv[g] ? mem_rdata : g_data[g];

      lacc_agu #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_agu (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_base  (g_sel[g] && (cfg_addr[1:0] == F_BASE)),
         .wr_stride(g_sel[g] && (cfg_addr[1:0] == F_STRIDE)),
         .wr_en    (g_sel[g] && (cfg_addr[1:0] == F_EN)),
         .wdata    (cfg_wdata),
         .load     (start),
         .adv      (g_adv[g]),
         .rdata    (mem_rdata),
         .base_o   (g_base[g]),
         .stride_o (g_strd[g]),
         .addr_o   (g_addr[g]),
         .en_o     (g_en[g]),
         .data_o   (g_data[g])
      );
   end

   lacc_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .en       (iter_end),
      .a        (g_op[0]),
      .b        (g_op[1]),
      .c        (g_op[2]),
      .acc_o    (acc),
      .acc_nxt_o(acc_nxt)
   );

   lacc_loopctl #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_loop (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .step    (iter_end),
      .run     (st_q == ST_RUN),
      .bound   (bound_q),
      .brk_sel (brk_q),
      .acc_nxt (acc_nxt),
      .iters_o (iters),
      .finish_o(finish)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cur_q   <= '0;
         brk_q   <= '0;
         bound_q <= '0;
         wbadr_q <= '0;
         done_q  <= 1'b0;
      end else begin
         if (clr_done) done_q <= 1'b0;
         if (wr_ok && cfg_addr == A_CTRL)  brk_q   <= cfg_wdata[2:1];
         if (wr_ok && cfg_addr == A_BOUND) bound_q <= cfg_wdata[CNT_W-1:0];
         if (wr_ok && cfg_addr == A_WBADR) wbadr_q <= cfg_wdata[ADDR_W-1:0];
         case (st_q)
            ST_IDLE: if (start) begin
               st_q   <= (bound_q == '0) ? ST_WB : ST_RUN;
               cur_q  <= first_g;
               done_q <= 1'b0;
            end
            ST_RUN: begin
               if (rd_hs) cur_q <= has_nxt ? nxt_g : first_g;
               if (finish) st_q <= ST_WB;
            end
            ST_WB: if (mem_req_ready) begin
               st_q   <= ST_IDLE;
               done_q <= 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_addr = wbadr_q;
      if (st_q != ST_WB) begin
         for (int g = 0; g < NUM_GEN; g++) if (cur_q == 2'(g)) mem_req_addr = g_addr[g];
      end
   end

   assign mem_req_valid = ((st_q == ST_RUN) && any_en) || (st_q == ST_WB);
   assign mem_req_we    = (st_q == ST_WB);
   assign mem_req_wdata = acc[DATA_W-1:0];
   assign irq           = done_q;

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         A_CTRL:  cfg_rdata = DATA_W'({brk_q, 1'b0});
         A_STAT:  cfg_rdata = DATA_W'({done_q, !idle});
         A_BOUND: cfg_rdata = DATA_W'(bound_q);
         A_ITERS: cfg_rdata = DATA_W'(iters);
         A_WBADR: cfg_rdata = DATA_W'(wbadr_q);
         A_ACCLO: cfg_rdata = acc[DATA_W-1:0];
         A_ACCHI: cfg_rdata = DATA_W'(acc >> DATA_W);
         default: begin
            for (int g = 0; g < NUM_GEN; g++) begin
               if (cfg_addr[4:2] == 3'((GEN_BASE_WORD / 4) + g)) begin
                  case (cfg_addr[1:0])
                     F_BASE:   cfg_rdata = DATA_W'(g_base[g]);
                     F_STRIDE: cfg_rdata = DATA_W'(g_strd[g]);
                     F_EN:     cfg_rdata = DATA_W'(g_en[g]);
                     default:  cfg_rdata = g_data[g];
                  endcase
               end
            end
         end
      endcase
   end

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));
   // R8
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(mem_req_valid && mem_req_we && mem_req_ready));
   // R10
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !clr_done && !start |=> irq);
   // R3
   busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!idle && done_q));
endmodule

// File: tb/loop_accel_ctrl_tb.sv
`timescale 1ns/1ps
module loop_accel_ctrl_tb;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;
   logic        mem_req_valid, mem_req_we, irq;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr, mem_req_wdata, mem_rdata;

   always #2.5 clk = ~clk;
   assign mem_rdata = mem_req_addr - 32'h100;

   loop_accel_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata), .irq(irq));

   int n_chk = 0, n_bad = 0;
   logic [64:0] exp_q[$];
   bit stall_en = 1'b0, counting = 1'b0;
   int unsigned lfsr = 32'h1;
   int run_cycles = 0, exp_iters = 0;
   longint m_acc = 0;
   logic [31:0] m_reg [3] = '{0, 0, 0};

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   // monitor: sets ready, then pops and compares every accepted request
   initial forever begin
      @(negedge clk);
      if (stall_en) begin
         lfsr = lfsr * 32'd1103515245 + 32'd12345;
         mem_req_ready = lfsr[16] | lfsr[21];
      end else mem_req_ready = 1'b1;
      #1;
      if (counting && !(mem_req_valid && mem_req_we)) run_cycles++;
      if (rst_n && mem_req_valid && mem_req_ready) begin
         if (mem_req_valid && mem_req_we) counting = 1'b0;
         if (exp_q.size() == 0) check("R4 unexpected request", {31'd0, mem_req_we, mem_req_addr}, 64'hDEAD);
         else begin
            logic [64:0] e;
            e = exp_q.pop_front();
            check("R4/R8 request", {31'd0, mem_req_we, mem_req_addr}, {31'd0, e[64], e[63:32]});
            if (mem_req_we) check("R8 result data", {32'd0, mem_req_wdata}, {32'd0, e[31:0]});
         end
      end
   end

   initial begin
      #(5.0 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
   endtask

   // driver: programs the job, builds the expected request stream, starts
   task automatic job(input logic [31:0] b0, b1, b2, s0, s1, s2, input logic [2:0] en,
                      input int bound, input int sel, input logic [31:0] wb);
      logic [31:0] b [3];
      logic [31:0] s [3];
      b = '{b0, b1, b2}; s = '{s0, s1, s2};
      for (int g = 0; g < 3; g++) begin
         wr(5'(8 + 4 * g), b[g]); wr(5'(9 + 4 * g), s[g]); wr(5'(10 + 4 * g), {31'd0, en[g]});
      end
      wr(5'd2, bound); wr(5'd4, wb);
      m_acc = 0; exp_iters = 0;
      for (int k = 0; k < bound; k++) begin
         bit brk;
         longint x0, x1, x2;
         for (int g = 0; g < 3; g++) if (en[g]) begin
            logic [31:0] a;
            a = b[g] + k * s[g];
            exp_q.push_back({1'b0, a, 32'd0});
            m_reg[g] = a - 32'h100;
         end
         x0 = $signed(m_reg[0]); x1 = $signed(m_reg[1]); x2 = $signed(m_reg[2]);
         m_acc = m_acc + x0 * x1 + x2;
         exp_iters++;
         brk = (sel == 1) ? (m_acc == 0) : (sel == 2) ? (m_acc < 0) : 1'b0;
         if (brk) break;
      end
      exp_q.push_back({1'b1, wb, m_acc[31:0]});
      run_cycles = 0;
      wr(5'd0, {29'd0, 2'(sel), 1'b1});
      counting = 1'b1;
   endtask

   task automatic finish_job(string tag, input int exp_cycles);
      logic [31:0] d;
      while (!irq) @(negedge clk);
      check({tag, " R10 irq"}, {63'd0, irq}, 64'd1);
      rd(5'd3, d); check({tag, " R11 iterations"}, {32'd0, d}, 64'(exp_iters));
      rd(5'd5, d); check({tag, " R5 acc low"}, {32'd0, d}, {32'd0, m_acc[31:0]});
      rd(5'd6, d); check({tag, " R5 acc high"}, {32'd0, d}, {32'd0, m_acc[63:32]});
      check({tag, " R8 all requests seen"}, 64'(exp_q.size()), 64'd0);
      if (exp_cycles >= 0) check({tag, " R5 loop cycles"}, 64'(run_cycles), 64'(exp_cycles));
   endtask

   initial begin
      logic [31:0] d, keep;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1
      rd(5'd1, d);  check("R1 status", {32'd0, d}, 64'd0);
      check("R1 irq/valid", {62'd0, irq, mem_req_valid}, 64'd0);
      rd(5'd5, d);  check("R1 acc", {32'd0, d}, 64'd0);
      rd(5'd15, d); check("R1 operand", {32'd0, d}, 64'd0);
      // R2
      wr(5'd12, 32'h1234_5678); rd(5'd12, d); check("R2 base readback", {32'd0, d}, 64'h1234_5678);
      wr(5'd2, 32'd7); rd(5'd2, d); check("R2 bound readback", {32'd0, d}, 64'd7);
      // R4 R5: all walkers, ready high
      job(32'h200, 32'h400, 32'h100, 32'd4, -32'sd8, 32'd12, 3'b111, 5, 0, 32'h800);
      finish_job("A", 15);
      // R10: writing 0 to done bit has no effect, writing 1 clears
      wr(5'd1, 32'd0); rd(5'd1, d); check("R10 done held", {32'd0, d}, 64'd2);
      wr(5'd1, 32'd2); rd(5'd1, d); check("R10 done cleared", {32'd0, d}, 64'd0);
      check("R10 irq cleared", {63'd0, irq}, 64'd0);
      // R4 R9 R3: one walker, random stalls, writes while busy ignored
      rd(5'd15, keep);
      stall_en = 1'b1;
      job(32'h100, 32'h0, 32'h0, 32'd0, 32'd0, 32'd0, 3'b001, 20, 0, 32'h804);
      rd(5'd1, d); check("R3 busy", {32'd0, d}, 64'd1);
      wr(5'd2, 32'd99); wr(5'd0, 32'd1);
      finish_job("B", -1);
      stall_en = 1'b0;
      rd(5'd2, d);  check("R3 bound write ignored while busy", {32'd0, d}, 64'd20);
      rd(5'd15, d); check("R4 disabled operand kept", {32'd0, d}, {32'd0, keep});
      rd(5'd11, d); check("R4 fetched operand", {32'd0, d}, 64'd0);
      // R6: bound 0, write only
      job(32'h300, 32'h300, 32'h300, 32'd4, 32'd4, 32'd4, 3'b111, 0, 0, 32'h808);
      finish_job("C", 0);
      check("R6 no iterations", 64'(exp_iters), 64'd0);
      // R5: no walker enabled, one cycle per iteration
      job(32'h0, 32'h0, 32'h0, 32'd0, 32'd0, 32'd0, 3'b000, 3, 0, 32'h80C);
      finish_job("D", 3);
      // R7: early exits with walker 2 only, slot 0 is zero
      job(32'h0, 32'h0, 32'h104, 32'd0, 32'd0, -32'sd4, 3'b100, 10, 1, 32'h810);
      finish_job("E", 3);
      check("R7 zero exit at iteration 3", 64'(exp_iters), 64'd3);
      job(32'h0, 32'h0, 32'h108, 32'd0, 32'd0, -32'sd8, 3'b100, 10, 2, 32'h814);
      finish_job("F", 4);
      check("R7 sign exit at iteration 4", 64'(exp_iters), 64'd4);
      job(32'h0, 32'h0, 32'h104, 32'd0, 32'd0, -32'sd4, 3'b100, 10, 3, 32'h818);
      finish_job("G", 10);
      check("R7 select 3 runs to bound", 64'(exp_iters), 64'd10);
      repeat (2) @(negedge clk);
      summary();
   end
endmodule